// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Front End

This block is the digital side of a two-channel 8-bit digital-to-analog converter. An external host drives a parallel data bus together with active-low chip-select and write strobes and a channel-select level. Each channel holds two registers. The staging register takes the bus value. The output register holds the code that drives the converter. Both output codes leave the block, together with a power-down status flag.

All pins are asynchronous to the system clock. Each pin passes through a two-flop synchroniser, and edges are found by comparing the last two synchronised samples. A write completes when the combined "chip select and write strobe both low" condition ends. The load strobe level at that moment picks the update mode. Low means the written channel's output register follows at once. High means the output register waits for the next falling edge of the load strobe, which then updates both channels together. A clear input forces both output codes to zero and has priority over every update. After reset the outputs stay at zero until the first write.

Every pin level must stay stable for at least two system clock periods, so that the synchroniser samples it.

Top module: `dual_dac_front`

## Requirements
- R1: While reset is asserted and just after it is released, with all strobes idle high, both output codes read 0x00 and `powered_down` reads 0.
- R2: A write, with `cs_n` and `wr_n` both low, ends when the first of them returns high. The value on `bus_data` during the write goes into the staging register of the channel selected by `chan_b`, where 0 selects channel A and 1 selects channel B. If `load_n` was low during the write, that channel's output code becomes the written value, and the other channel's code does not change.
- R3: If `load_n` was high during the write, neither output code changes because of that write.
- R4: A falling edge of `load_n` copies each channel's staging register into its output register, for both channels at once.
- R5: A write that begins while `load_n` is still low acts as an automatic-update write. The later rising edge of `load_n` changes no output code.
- R6: While `clr_n` is low, both output codes read 0x00. The staging registers keep their contents through a clear.
- R7: A falling edge of `load_n` while `clr_n` is low is ignored. The codes are still 0x00 after `clr_n` returns high.
- R8: After reset both output codes stay 0x00 until a write occurs. A first write with `load_n` high leaves both codes at 0x00.
- R9: `powered_down` reads 1 while `pwrdn_n` is low and 0 otherwise. Entering and leaving power-down does not change either output code.
- R10: Output codes are straight binary: the values 0x00, 0x80 and 0xFF written to the bus appear unchanged on the output.
- R11: An output code changes at the third rising clock edge after the pin change that completes the write, and not at the second.
- R12: An automatic-update write made while `clr_n` is low leaves the output code at 0x00. Its data is still held in the staging register, and a later load edge shows it.
- R13: Pulsing `wr_n` while `cs_n` stays high writes nothing. A later load edge shows the earlier staging contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, fast enough to sample every pin pulse twice |
| rst_n | input | 1 | Active-low power-on reset |
| bus_data | input | 8 | Parallel data bus |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| chan_b | input | 1 | Channel select: 0 = channel A, 1 = channel B |
| load_n | input | 1 | Active-low load strobe; sets the update mode and fires simultaneous updates |
| clr_n | input | 1 | Active-low clear of both output registers |
| pwrdn_n | input | 1 | Active-low power-down request |
| code_a | output | 8 | Channel A output register code |
| code_b | output | 8 | Channel B output register code |
| powered_down | output | 1 | High while power-down is requested |

## Verification
The bench builds the block with its default parameters: an 8-bit code and a two-stage synchroniser. The 8-bit code makes the endpoints 0x00 and 0xFF and the mid-scale code 0x80 reachable with direct writes. The two-stage synchroniser makes the update latency exactly three clock edges, so the bench can check the edge before the update and the edge of the update one at a time. Clear and power-down are held for several cycles. This lets the bench check that a load edge during a clear is discarded, and that a write during a clear still reaches the staging register.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

  // Bit positions inside the packed control-pin vector
  localparam int unsigned PIN_CS   = 0;
  localparam int unsigned PIN_WR   = 1;
  localparam int unsigned PIN_CHAN = 2;
  localparam int unsigned PIN_LOAD = 3;
  localparam int unsigned PIN_CLR  = 4;
  localparam int unsigned PIN_PD   = 5;
  localparam int unsigned PIN_CNT  = 6;

  // Idle levels: all strobes high, channel select low
  localparam logic [PIN_CNT-1:0] PIN_IDLE = 6'b111011;

  // A level that was high and is now low
  function automatic logic fell_edge(input logic prev_lvl, input logic now_lvl);
    return prev_lvl && !now_lvl;
  endfunction

  // Write condition active: select and strobe both low
  function automatic logic wr_active(input logic cs_lvl, input logic wr_lvl);
    return !cs_lvl && !wr_lvl;
  endfunction

  // Write completes when the condition goes from active to inactive
  function automatic logic wr_release(input logic act_prev, input logic act_now);
    return act_prev && !act_now;
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] lvl_now,
  output logic [W-1:0] lvl_prev
);
  // STAGES synchroniser flops plus one history flop for edge detection
  localparam int unsigned DEPTH = STAGES + 1;

  logic [W-1:0] chain [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= pin_in;
      for (int i = 1; i < DEPTH; i++) chain[i] <= chain[i-1];
    end
  end

  assign lvl_now  = chain[STAGES-1];
  assign lvl_prev = chain[STAGES];

endmodule

// File: rtl/dac_fe_ctrl.sv
module dac_fe_ctrl
  import dac_fe_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned NCH = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PIN_CNT-1:0] pins_now,
  input  logic [PIN_CNT-1:0] pins_prev,
  input  logic [DW-1:0]      data_prev,
  output logic [NCH-1:0]     wr_hit,
  output logic [DW-1:0]      wr_data,
  output logic               auto_upd,
  output logic               sim_upd,
  output logic               clr_act,
  output logic               transparent,
  output logic               pd_flag
);
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1;

  logic act_now, act_prev, wr_evt;
  logic [CHW-1:0] wr_chan;

  assign act_now  = wr_active(pins_now[PIN_CS],  pins_now[PIN_WR]);
  assign act_prev = wr_active(pins_prev[PIN_CS], pins_prev[PIN_WR]);
  assign wr_evt   = wr_release(act_prev, act_now);

  // Data, channel and load level come from the last sample inside the write
  assign wr_chan  = CHW'(pins_prev[PIN_CHAN]);
  assign wr_data  = data_prev;
  assign auto_upd = !pins_prev[PIN_LOAD];

  assign clr_act  = !pins_now[PIN_CLR];
  assign sim_upd  = fell_edge(pins_prev[PIN_LOAD], pins_now[PIN_LOAD]) && !clr_act;
  assign pd_flag  = !pins_now[PIN_PD];

  for (genvar c = 0; c < NCH; c++) begin : g_hit
    assign wr_hit[c] = wr_evt && (wr_chan == CHW'(c));
  end

  // Power-on transparent state, left for good on the first completed write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      transparent <= 1'b1;
    else if (wr_evt) transparent <= 1'b0;
  end

  p_por_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !transparent |=> !transparent);

  p_hit_needs_write_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_hit) |-> !pins_prev[PIN_CS]);

endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [DW-1:0] wr_data,
  input  logic          auto_upd,
  input  logic          sim_upd,
  input  logic          clr_act,
  input  logic          transparent,
  output logic [DW-1:0] stage_code,
  output logic [DW-1:0] out_code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stage_code <= '0;
    else if (wr_hit) stage_code <= wr_data;
  end

  // Clear first, then the write-edge update, then load edge, then power-on pass-through
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    out_code <= '0;
    else if (clr_act)              out_code <= '0;
    else if (wr_hit && auto_upd)   out_code <= wr_data;
    else if (sim_upd)              out_code <= stage_code;
    else if (transparent)          out_code <= stage_code;
  end

  p_clr_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> (out_code == '0));

  p_stage_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(stage_code));

  p_auto_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && auto_upd && !clr_act) |=> (out_code == $past(wr_data)));

  p_sim_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sim_upd && !clr_act && !wr_hit) |=> (out_code == $past(stage_code)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_act && !wr_hit && !sim_upd && !transparent) |=> $stable(out_code));

endmodule

// File: rtl/dual_dac_front.sv
module dual_dac_front
  import dac_fe_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_data,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic          chan_b,
  input  logic          load_n,
  input  logic          clr_n,
  input  logic          pwrdn_n,
  output logic [DW-1:0] code_a,
  output logic [DW-1:0] code_b,
  output logic          powered_down
);
  localparam int unsigned NCH = 2;

  logic [PIN_CNT-1:0] pins_raw, pins_now, pins_prev;
  logic [DW-1:0]      data_now, data_prev;

  assign pins_raw[PIN_CS]   = cs_n;
  assign pins_raw[PIN_WR]   = wr_n;
  assign pins_raw[PIN_CHAN] = chan_b;
  assign pins_raw[PIN_LOAD] = load_n;
  assign pins_raw[PIN_CLR]  = clr_n;
  assign pins_raw[PIN_PD]   = pwrdn_n;

  pin_sync #(.W(PIN_CNT), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pins_raw),
    .lvl_now(pins_now), .lvl_prev(pins_prev));

  pin_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(bus_data),
    .lvl_now(data_now), .lvl_prev(data_prev));

  logic [NCH-1:0] wr_hit;
  logic [DW-1:0]  wr_data;
  logic           auto_upd, sim_upd, clr_act, transparent, pd_flag;

  dac_fe_ctrl #(.DW(DW), .NCH(NCH)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .pins_now(pins_now), .pins_prev(pins_prev), .data_prev(data_prev),
    .wr_hit(wr_hit), .wr_data(wr_data), .auto_upd(auto_upd),
    .sim_upd(sim_upd), .clr_act(clr_act), .transparent(transparent),
    .pd_flag(pd_flag));

  logic [DW-1:0] stage_code [NCH];
  logic [DW-1:0] out_code   [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dac_channel #(.DW(DW)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_hit(wr_hit[c]), .wr_data(wr_data), .auto_upd(auto_upd),
      .sim_upd(sim_upd), .clr_act(clr_act), .transparent(transparent),
      .stage_code(stage_code[c]), .out_code(out_code[c]));
  end

  assign code_a       = out_code[0];
  assign code_b       = out_code[1];
  assign powered_down = pd_flag;

  // data_now is part of the synchroniser chain; only the history sample is consumed
  logic unused_ok;
  assign unused_ok = ^data_now;

  p_por_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    transparent |-> (code_a == '0 && code_b == '0));

  p_pd_keeps_codes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(pd_flag) && !clr_act && !(|wr_hit) && !sim_upd && !transparent)
      |=> (code_a == $past(code_a) && code_b == $past(code_b)));

  p_ignored_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_act && !(|wr_hit)) |=> (code_a == '0 && code_b == '0));

endmodule

// File: tb/sim_dual_dac_front.sv
module sim_dual_dac_front;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_data = 8'h00;
  logic       cs_n = 1'b1, wr_n = 1'b1, chan_b = 1'b0;
  logic       load_n = 1'b1, clr_n = 1'b1, pwrdn_n = 1'b1;
  logic [7:0] code_a, code_b;
  logic       powered_down;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_dac_front u0 (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .cs_n(cs_n), .wr_n(wr_n),
    .chan_b(chan_b), .load_n(load_n), .clr_n(clr_n), .pwrdn_n(pwrdn_n),
    .code_a(code_a), .code_b(code_b), .powered_down(powered_down));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_write(input logic ch, input logic [7:0] d, input logic use_cs);
    @(negedge clk);
    chan_b = ch; bus_data = d;
    idle(1);
    cs_n = !use_cs;
    idle(1);
    wr_n = 1'b0;
    idle(3);
    wr_n = 1'b1;
    idle(1);
    cs_n = 1'b1;
    idle(3);
    bus_data = 8'hA5;
    idle(3);
  endtask

  task automatic pulse_load();
    @(negedge clk); load_n = 1'b0;
    idle(3);        load_n = 1'b1;
    idle(5);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle(3);
    chk("R1 reset code_a", code_a, 8'h00);
    chk("R1 reset code_b", code_b, 8'h00);
    chk("R1 reset pd flag", {7'd0, powered_down}, 8'h00);
    rst_n = 1'b1;
    idle(4);
    chk("R1 after reset code_a", code_a, 8'h00);
    chk("R1 after reset pd flag", {7'd0, powered_down}, 8'h00);
  endtask

  task automatic t_por();
    do_write(1'b0, 8'h5A, 1'b1);
    chk("R8 first write held code_a", code_a, 8'h00);
    chk("R8 first write held code_b", code_b, 8'h00);
    pulse_load();
    chk("R4 load edge code_a", code_a, 8'h5A);
    chk("R8 untouched channel code_b", code_b, 8'h00);
  endtask

  task automatic t_auto();
    load_n = 1'b0;
    do_write(1'b1, 8'h33, 1'b1);
    chk("R2 auto code_b", code_b, 8'h33);
    chk("R2 other channel code_a", code_a, 8'h5A);
    load_n = 1'b1;
    idle(4);
    chk("R5 load rise no change code_b", code_b, 8'h33);
  endtask

  task automatic t_latency();
    @(negedge clk);
    load_n = 1'b0; chan_b = 1'b0; bus_data = 8'h81;
    idle(2);
    cs_n = 1'b0; wr_n = 1'b0;
    idle(3);
    wr_n = 1'b1; cs_n = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R11 not yet at edge 2", code_a, 8'h5A);
    @(posedge clk); #1;
    chk("R11 updated at edge 3", code_a, 8'h81);
    idle(3);
    load_n = 1'b1;
    idle(4);
  endtask

  task automatic t_sim();
    do_write(1'b0, 8'h11, 1'b1);
    do_write(1'b1, 8'h22, 1'b1);
    chk("R3 deferred code_a", code_a, 8'h81);
    chk("R3 deferred code_b", code_b, 8'h33);
    pulse_load();
    chk("R4 simultaneous code_a", code_a, 8'h11);
    chk("R4 simultaneous code_b", code_b, 8'h22);
  endtask

  task automatic t_late_load();
    @(negedge clk); load_n = 1'b0;
    do_write(1'b0, 8'h44, 1'b1);
    chk("R5 write during low load code_a", code_a, 8'h44);
    load_n = 1'b1;
    idle(4);
    chk("R5 rise after write code_a", code_a, 8'h44);
  endtask

  task automatic t_codes();
    load_n = 1'b0;
    do_write(1'b1, 8'h00, 1'b1);
    chk("R10 zero code", code_b, 8'h00);
    do_write(1'b1, 8'hFF, 1'b1);
    chk("R10 full code", code_b, 8'hFF);
    do_write(1'b1, 8'h80, 1'b1);
    chk("R10 mid code", code_b, 8'h80);
    load_n = 1'b1;
    idle(4);
  endtask

  task automatic t_clear();
    do_write(1'b0, 8'h99, 1'b1);
    @(negedge clk); clr_n = 1'b0;
    idle(4);
    chk("R6 clear code_a", code_a, 8'h00);
    chk("R6 clear code_b", code_b, 8'h00);
    pulse_load();
    chk("R7 load under clear code_a", code_a, 8'h00);
    clr_n = 1'b1;
    idle(4);
    chk("R7 after clear code_a", code_a, 8'h00);
    chk("R7 after clear code_b", code_b, 8'h00);
    pulse_load();
    chk("R6 staging kept code_a", code_a, 8'h99);
    chk("R6 staging kept code_b", code_b, 8'h80);
  endtask

  task automatic t_clr_priority();
    @(negedge clk); clr_n = 1'b0; load_n = 1'b0;
    do_write(1'b1, 8'h5C, 1'b1);
    chk("R12 auto under clear code_b", code_b, 8'h00);
    load_n = 1'b1;
    idle(3);
    clr_n = 1'b1;
    idle(4);
    chk("R12 after clear code_b", code_b, 8'h00);
    pulse_load();
    chk("R12 staged data code_b", code_b, 8'h5C);
  endtask

  task automatic t_no_select();
    load_n = 1'b0;
    do_write(1'b0, 8'h3E, 1'b0);
    chk("R13 no select code_a", code_a, 8'h99);
    load_n = 1'b1;
    idle(4);
    pulse_load();
    chk("R13 staging untouched code_a", code_a, 8'h99);
  endtask

  task automatic t_pd();
    @(negedge clk); pwrdn_n = 1'b0;
    idle(4);
    chk("R9 pd flag set", {7'd0, powered_down}, 8'h01);
    chk("R9 pd code_a kept", code_a, 8'h99);
    chk("R9 pd code_b kept", code_b, 8'h5C);
    pwrdn_n = 1'b1;
    idle(4);
    chk("R9 pd flag clear", {7'd0, powered_down}, 8'h00);
    chk("R9 exit code_a kept", code_a, 8'h99);
    chk("R9 exit code_b kept", code_b, 8'h5C);
  endtask

  initial begin
    t_reset();
    t_por();
    t_auto();
    t_latency();
    t_sim();
    t_late_load();
    t_codes();
    t_clear();
    t_clr_priority();
    t_no_select();
    t_pd();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule